// File: doc/BRIEF.md
# Deferred-Commit Store Buffer for a Staged Data Cache

This block sits beside the data array of a pipelined cache. The array access is split over several stages, and the tag comparison only finishes later. A store cannot be written into the array on the way through, because an array write cannot be taken back if the tag then reports a miss. The block therefore parks one store, its word address, data and byte enables, in a single entry. The store is released into the array only after its tag result has come back as a hit. The write happens in a cycle when the array is idle, or at the latest when the next store arrives and needs the entry.

Each store spends exactly one cycle in a checking state. In that cycle the tag result for it is presented on `tc_hit`. On a hit the entry is confirmed. On a miss the entry is dropped and a one-cycle miss indication is raised; miss handling happens elsewhere. Loads present their address together with the word the array returned for it. The block compares the word address with both the confirmed entry and a write that is still in flight to the array. It returns the word with the newest bytes laid over it, one cycle later.

Top module: `dstore_buf`

## Requirements
- R1: In the cycle after reset is asserted, `arr_we`, `ld_rvalid` and `st_miss` are all 0.
- R2: A store whose tag result is a miss (`tc_hit`=0 in the cycle after the store was presented) is never written to the array.
- R3: `arr_we` is 1 only in the cycle after a cycle in which `arr_free` or `st_valid` was 1. A confirmed store waits in the entry, unwritten, while neither is asserted.
- R4: When a store arrives while the entry holds a confirmed store, the old store appears on the write port in the next cycle and the new store is captured in the same edge.
- R5: `st_miss` is 1 for exactly the cycle after a checking cycle with `tc_hit`=0. It is 0 at all other times.
- R6: A load whose word address (address bits above the byte offset) equals that of the confirmed entry returns the entry's bytes where its byte enable bit i is set (bits [8i+7:8i]). The array's bytes are returned elsewhere, whatever the load's byte offset.
- R7: A load in the cycle where an earlier store is being written to the array (`arr_we`=1, same word) receives that store's enabled bytes over `ld_array_data`.
- R8: `ld_rvalid` is 1 exactly one cycle after `ld_valid`, with `ld_rdata` carrying the result.
- R9: A load presented in the same cycle as a store does not see that store.
- R10: After all confirmed stores are drained, the array holds each confirmed store merged by byte enable, in store order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request this cycle |
| st_addr | input | AW | Store byte address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| tc_hit | input | 1 | Tag result for the store presented one cycle earlier |
| arr_free | input | 1 | Data array has an idle write slot this cycle |
| ld_valid | input | 1 | Load request this cycle |
| ld_addr | input | AW | Load byte address |
| ld_array_data | input | DW | Word read from the array for `ld_addr` this cycle |
| arr_we | output | 1 | Array write enable (registered) |
| arr_waddr | output | AW-log2(DW/8) | Array word address |
| arr_wdata | output | DW | Array write data |
| arr_wbe | output | DW/8 | Array byte write enables |
| ld_rvalid | output | 1 | Load result valid |
| ld_rdata | output | DW | Load result with forwarded bytes |
| st_miss | output | 1 | Pulse: a checked store missed and was dropped |

## Verification
Some properties are checked on every clock. The write port is quiet after a miss and is only used when a slot was offered. An occupied entry gives way to a new store by writing at once. The miss pulse and the load result appear with one cycle of latency. Whether the bytes returned are correct can only be shown by the bench scenarios. It keeps its own model of the array and of committed memory, and checks partial byte enables, forwarding from a write still in flight, a load beside a store in the same cycle, and the array contents after the final drain.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_CHECK = 2'd1,
    SLOT_HELD  = 2'd2
  } slot_state_e;
endpackage

// File: rtl/dsb_merge.sv
module dsb_merge #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   base,
  input  logic [DW-1:0]   over,
  input  logic [DW/8-1:0] be,
  input  logic            sel,
  output logic [DW-1:0]   merged
);
  localparam int BW = DW / 8;

  for (genvar b = 0; b < BW; b++) begin : g_byte
    assign merged[b*8 +: 8] = (sel && be[b]) ? over[b*8 +: 8] : base[b*8 +: 8];
  end
endmodule

// File: rtl/dsb_slot.sv
module dsb_slot
  import dsb_pkg::*;
#(
  parameter int WAW = 8,
  parameter int DW  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_valid,
  input  logic [WAW-1:0]  st_waddr,
  input  logic [DW-1:0]   st_data,
  input  logic [DW/8-1:0] st_be,
  input  logic            tc_hit,
  input  logic            arr_free,
  output logic            live,
  output logic            checking,
  output logic            held,
  output logic            drop,
  output logic            drain,
  output logic [WAW-1:0]  waddr,
  output logic [DW-1:0]   data,
  output logic [DW/8-1:0] be
);
  slot_state_e state, state_nxt;

  assign checking = (state == SLOT_CHECK);
  assign held     = (state == SLOT_HELD);
  assign live     = held || (checking && tc_hit);
  assign drop     = checking && !tc_hit;
  assign drain    = live && (arr_free || st_valid);

  always_comb begin
    state_nxt = state;
    if (st_valid)              state_nxt = SLOT_CHECK;
    else if (drain || drop)    state_nxt = SLOT_EMPTY;
    else if (checking)         state_nxt = SLOT_HELD;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SLOT_EMPTY;
    else     state <= state_nxt;
  end

  always_ff @(posedge clk) begin
    if (st_valid) begin
      waddr <= st_waddr;
      data  <= st_data;
      be    <= st_be;
    end
  end

  // R4: an arriving store always enters the checking state next cycle
  a_r4_store_captured: assert property (@(posedge clk) disable iff (rst)
    st_valid |=> checking);
  // R2: the held state is only reached through a confirmed hit
  a_r2_held_after_hit: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> $past(checking && tc_hit));
endmodule

// File: rtl/dsb_wport.sv
module dsb_wport #(
  parameter int WAW = 8,
  parameter int DW  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            drain,
  input  logic [WAW-1:0]  src_waddr,
  input  logic [DW-1:0]   src_data,
  input  logic [DW/8-1:0] src_be,
  output logic            we,
  output logic [WAW-1:0]  waddr,
  output logic [DW-1:0]   wdata,
  output logic [DW/8-1:0] wbe
);
  always_ff @(posedge clk) begin
    if (rst) we <= 1'b0;
    else     we <= drain;
  end

  always_ff @(posedge clk) begin
    if (drain) begin
      waddr <= src_waddr;
      wdata <= src_data;
      wbe   <= src_be;
    end
  end

  // R3: a write only follows a cycle that was asked to drain
  a_r3_we_follows_drain: assert property (@(posedge clk) disable iff (rst)
    !drain |=> !we);
endmodule

// File: rtl/dstore_buf.sv
module dstore_buf #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          st_valid,
  input  logic [AW-1:0]                 st_addr,
  input  logic [DW-1:0]                 st_data,
  input  logic [DW/8-1:0]               st_be,
  input  logic                          tc_hit,
  input  logic                          arr_free,
  input  logic                          ld_valid,
  input  logic [AW-1:0]                 ld_addr,
  input  logic [DW-1:0]                 ld_array_data,
  output logic                          arr_we,
  output logic [AW-$clog2(DW/8)-1:0]    arr_waddr,
  output logic [DW-1:0]                 arr_wdata,
  output logic [DW/8-1:0]               arr_wbe,
  output logic                          ld_rvalid,
  output logic [DW-1:0]                 ld_rdata,
  output logic                          st_miss
);
  localparam int BW   = DW / 8;
  localparam int OFFW = $clog2(BW);
  localparam int WAW  = AW - OFFW;

  logic           s_live, s_checking, s_held, s_drop, s_drain;
  logic [WAW-1:0] s_waddr;
  logic [DW-1:0]  s_data;
  logic [BW-1:0]  s_be;
  logic [WAW-1:0] ld_waddr;
  logic           hit_wp, hit_slot;
  logic [DW-1:0]  after_wp, after_slot;

  dsb_slot #(.WAW(WAW), .DW(DW)) u_slot (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_waddr(st_addr[AW-1:OFFW]),
    .st_data(st_data), .st_be(st_be),
    .tc_hit(tc_hit), .arr_free(arr_free),
    .live(s_live), .checking(s_checking), .held(s_held),
    .drop(s_drop), .drain(s_drain),
    .waddr(s_waddr), .data(s_data), .be(s_be)
  );

  dsb_wport #(.WAW(WAW), .DW(DW)) u_wport (
    .clk(clk), .rst(rst), .drain(s_drain),
    .src_waddr(s_waddr), .src_data(s_data), .src_be(s_be),
    .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata), .wbe(arr_wbe)
  );

  assign ld_waddr = ld_addr[AW-1:OFFW];
  assign hit_wp   = arr_we && (arr_waddr == ld_waddr);
  assign hit_slot = s_live && (s_waddr == ld_waddr);

  // older in-flight write first, newer buffered store on top
  dsb_merge #(.DW(DW)) u_merge_wp (
    .base(ld_array_data), .over(arr_wdata), .be(arr_wbe),
    .sel(hit_wp), .merged(after_wp)
  );
  dsb_merge #(.DW(DW)) u_merge_slot (
    .base(after_wp), .over(s_data), .be(s_be),
    .sel(hit_slot), .merged(after_slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_rvalid <= 1'b0;
      st_miss   <= 1'b0;
    end else begin
      ld_rvalid <= ld_valid;
      st_miss   <= s_drop;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_valid) ld_rdata <= after_slot;
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!arr_we && !ld_rvalid && !st_miss));
  // R2
  a_r2_miss_never_written: assert property (@(posedge clk) disable iff (rst)
    (s_checking && !tc_hit) |=> !arr_we);
  // R3
  a_r3_write_needs_slot: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> $past(arr_free || st_valid));
  // R4
  a_r4_full_store_drains: assert property (@(posedge clk) disable iff (rst)
    (s_live && st_valid) |=> arr_we);
  // R5
  a_r5_miss_pulse: assert property (@(posedge clk) disable iff (rst)
    st_miss |-> $past(s_checking && !tc_hit));
  // R8
  a_r8_load_latency: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> ld_rvalid);
  a_r8_no_spurious_result: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> !ld_rvalid);
endmodule

// File: tb/dstore_buf_bench.sv
`timescale 1ns/1ps
module dstore_buf_bench;
  localparam int AW = 10, DW = 32, BW = DW/8, OFFW = 2, WAW = AW - OFFW;
  localparam int NW = 1 << WAW;

  logic clk = 1'b0, rst = 1'b1;
  logic st_valid = 0, tc_hit = 0, arr_free = 0, ld_valid = 0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0, ld_array_data;
  logic [BW-1:0] st_be = '0;
  logic arr_we, ld_rvalid, st_miss;
  logic [WAW-1:0] arr_waddr;
  logic [DW-1:0] arr_wdata, ld_rdata;
  logic [BW-1:0] arr_wbe;

  always #4 clk = ~clk;

  dstore_buf #(.AW(AW), .DW(DW)) u_dstore_buf (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be), .tc_hit(tc_hit), .arr_free(arr_free),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_array_data(ld_array_data),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .arr_wbe(arr_wbe), .ld_rvalid(ld_rvalid), .ld_rdata(ld_rdata),
    .st_miss(st_miss)
  );

  function automatic logic [DW-1:0] fmerge(logic [DW-1:0] b, logic [DW-1:0] o,
                                           logic [BW-1:0] e);
    logic [DW-1:0] r = b;
    for (int i = 0; i < BW; i++) if (e[i]) r[i*8 +: 8] = o[i*8 +: 8];
    return r;
  endfunction

  // environment array: synchronous write at the clock edge
  logic [DW-1:0] mem [NW];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) mem[i] <= '0;
    end else if (arr_we) begin
      mem[arr_waddr] <= fmerge(mem[arr_waddr], arr_wdata, arr_wbe);
    end
  end
  assign ld_array_data = mem[ld_addr[AW-1:OFFW]];

  logic [DW-1:0] gold [NW];
  int tests = 0, fails = 0;
  bit done = 0;

  bit            prev_st = 0;
  logic [AW-1:0] prev_a;
  logic [DW-1:0] prev_d;
  logic [BW-1:0] prev_be;
  bit            exp_ld = 0, exp_miss = 0;
  logic [DW-1:0] exp_data;
  string         exp_tag = "R8";

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit sv, logic [AW-1:0] sa, logic [DW-1:0] sd, logic [BW-1:0] sb,
                     bit lv, logic [AW-1:0] la, bit fr, bit ht, string tag);
    // results of the previous cycle
    chk(ld_rvalid == exp_ld, "R8", {31'b0, ld_rvalid}, {31'b0, exp_ld});
    if (exp_ld) chk(ld_rdata == exp_data, exp_tag, ld_rdata, exp_data);
    chk(st_miss == exp_miss, "R5", {31'b0, st_miss}, {31'b0, exp_miss});
    // the tag result resolves the store presented last cycle
    if (prev_st && ht) gold[prev_a[AW-1:OFFW]] = fmerge(gold[prev_a[AW-1:OFFW]], prev_d, prev_be);
    exp_miss = prev_st && !ht;
    exp_ld   = lv;
    exp_data = gold[la[AW-1:OFFW]];   // R9: this cycle's store not yet visible
    exp_tag  = tag;
    prev_st = sv; prev_a = sa; prev_d = sd; prev_be = sb;
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
    ld_valid = lv; ld_addr = la; arr_free = fr; tc_hit = ht;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(bit fr);
    cyc(0, '0, '0, '0, 0, '0, fr, 1, "R3");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NW; i++) gold[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(!arr_we && !ld_rvalid && !st_miss, "R1", {29'b0, arr_we, ld_rvalid, st_miss}, '0);

    // R6: full store held, load forwarded, byte offset ignored by compare
    cyc(1, 10'd4, 32'h1122_3344, 4'hF, 0, '0, 0, 1, "R6");
    cyc(0, '0, '0, '0, 1, 10'd4, 0, 1, "R6");
    cyc(0, '0, '0, '0, 1, 10'd7, 0, 1, "R6");
    idle(0);
    // R3: held store not yet in the array without a free slot
    chk(mem[1] == 32'h0 && !arr_we, "R3", mem[1], 32'h0);
    // R7: drain, then load while the write is in flight
    idle(1);
    chk(arr_we && arr_waddr == 8'd1, "R3", {31'b0, arr_we}, 32'h1);
    cyc(0, '0, '0, '0, 1, 10'd5, 0, 1, "R7");
    // R6: partial byte enable merge over the array word
    cyc(1, 10'd4, 32'hAABB_CCDD, 4'h3, 0, '0, 0, 1, "R6");
    cyc(0, '0, '0, '0, 1, 10'd6, 0, 1, "R6");
    // R2/R5: store that misses is dropped
    cyc(1, 10'd8, 32'hDEAD_BEEF, 4'hF, 0, '0, 1, 1, "R2");
    cyc(0, '0, '0, '0, 1, 10'd8, 1, 0, "R2");
    cyc(0, '0, '0, '0, 1, 10'd8, 1, 1, "R2");
    // R4: confirmed entry displaced by a new store, no free slot
    cyc(1, 10'd12, 32'h0303_0303, 4'hF, 0, '0, 0, 1, "R4");
    cyc(1, 10'd16, 32'h0404_0404, 4'hF, 0, '0, 0, 1, "R4");
    chk(arr_we && arr_waddr == 8'd3 && arr_wdata == 32'h0303_0303, "R4",
        arr_wdata, 32'h0303_0303);
    // R9: load and store to the same word in the same cycle
    cyc(1, 10'd16, 32'h5555_6666, 4'hC, 1, 10'd16, 0, 1, "R9");
    cyc(0, '0, '0, '0, 1, 10'd16, 0, 1, "R6");

    // random traffic over a small window of words
    for (int n = 0; n < 4000; n++) begin
      cyc(($urandom % 3) == 0, 10'($urandom % 32), $urandom, 4'($urandom),
          ($urandom % 2) == 0, 10'($urandom % 32),
          ($urandom % 4) == 0, ($urandom % 5) != 0, "R6");
    end

    // drain everything, then compare the array against the committed model
    idle(1); idle(1); idle(1); idle(1);
    for (int i = 0; i < 16; i++)
      chk(mem[i] == gold[i], (i == 2) ? "R2" : "R10", mem[i], gold[i]);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule